// File: doc/BRIEF.md
# Windowed Watchdog Timer with Configuration Lock

The block is a watchdog down-counter that advances on a slow-clock enable pulse inside the system clock domain. Software controls it through a small register port. A mode register selects the halt behaviour during processor debug and system idle, a global disable, and which fault conditions raise the reset output. A timing register holds the reload period and a minimum-restart threshold. Software restarts the count by writing a keyed command to the control word. A restart that comes while the count is still above the threshold is a fault, just as letting the count run out is a fault.

A keyed lock command freezes both configuration registers until the next hardware reset. Rewriting the mode register shortly after a restart is known to shorten the period. The block therefore counts slow ticks after every accepted restart and records any mode write that lands inside that window. A status word keeps sticky cause bits and shows the live count.

Top module: `wdog_window`

## Requirements
- R1: After reset the mode register (offset 0x4) reads 0x00000030, the timing register (offset 0x8) reads 0x0FFF0FFF, the status flags (offset 0xC, bits [3:0]) read 0, the count (status bits [27:16]) reads 0xFFF and the reset output is low.
- R2: A write to the control word (offset 0x0) with key 0xA5 in bits [31:24] and bit 0 set is an accepted restart: it loads the count with the period in timing bits [11:0]. A control write carrying any other key leaves the count unchanged.
- R3: While the watchdog is running, each slow-tick pulse lowers the count by one.
- R4: With mode bit 4 set, the tick that takes the count from 1 to 0 gives a reset pulse exactly one system clock wide and sets status bit 0. The count then stays at 0 with no further pulse until a restart. With bit 4 clear, reaching 0 gives no pulse.
- R5: With mode bit 5 set, an accepted restart while the count is above the threshold in timing bits [27:16] gives one reset pulse and sets status bit 1. A restart at or below the threshold gives none. With bit 5 clear an early restart gives no pulse. In every case the count is reloaded.
- R6: With mode bit 12 set, the count holds and no reset pulse is produced, whether from underflow or from an early restart.
- R7: With mode bit 29 set, the count holds while the debug input is high. With mode bit 28 set, the count holds while the idle input is high. With these bits clear, those inputs have no effect.
- R8: A control write with key 0xA5 and bit 1 set locks the block. Status bit 3 then reads 1, and writes to the mode and timing registers are ignored. A lock command with a wrong key is ignored. Only a hardware reset clears the lock.
- R9: An accepted mode write made fewer than 3 slow ticks after an accepted restart sets sticky status bit 2. A mode write made 3 or more ticks after the restart does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| slow_tick | input | 1 | One-cycle slow-clock enable pulse |
| cpu_debug | input | 1 | Processor is in debug state |
| sys_idle | input | 1 | System is in idle state |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The counter is run with underflow reporting switched on and then off. This separates a missing pulse from a pulse that fires at the wrong count. The count is also left parked at zero, to show that the pulse fires only once. Restarts are issued above the threshold, exactly at it, and with window checking off. This pins down the strict comparison and the enable bit. Each halt source is raised with its mode bit set and then with it clear, so a swapped or ignored bit shows up in the count. Mode writes are placed 0, 2 and 3 ticks after a restart, which brackets the edge of the guard window.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  localparam int DATA_W   = 32;
  localparam int OFF_CTRL = 0;
  localparam int OFF_MODE = 4;
  localparam int OFF_TIME = 8;
  localparam int OFF_STAT = 12;

  localparam logic [7:0] CMD_KEY = 8'hA5;
  localparam int CB_RESTART = 0;
  localparam int CB_LOCK    = 1;

  localparam int MB_UFL_RST   = 4;
  localparam int MB_EARLY_RST = 5;
  localparam int MB_DISABLE   = 12;
  localparam int MB_IDLE_HOLD = 28;
  localparam int MB_DBG_HOLD  = 29;

  localparam logic [DATA_W-1:0] MODE_RESET = 32'h0000_0030;
  localparam logic [DATA_W-1:0] MODE_MASK  = 32'h3000_1030;

  localparam int THR_LSB = 16;
endpackage

// File: rtl/wdw_regs.sv
module wdw_regs
  import wdw_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              uf_evt,
  input  logic              er_evt,
  input  logic              guard_act,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] time_q,
  output logic              lock_q,
  output logic              restart,
  output logic              mode_wr_acc,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] FIELD_ONES = DATA_W'((64'd1 << CNT_W) - 64'd1);
  localparam logic [DATA_W-1:0] TIME_MASK  = (FIELD_ONES << THR_LSB) | FIELD_ONES;

  logic              key_ok, ctrl_wr, lock_set, time_wr_acc;
  logic [DATA_W-1:0] mode_d, time_d;
  logic              lock_d;
  logic [2:0]        flag_q, flag_d;

  always_comb begin
    key_ok      = (wdata[31:24] == CMD_KEY);
    ctrl_wr     = wr_en && (addr == ADDR_W'(OFF_CTRL));
    restart     = ctrl_wr && key_ok && wdata[CB_RESTART];
    lock_set    = ctrl_wr && key_ok && wdata[CB_LOCK];
    mode_wr_acc = wr_en && (addr == ADDR_W'(OFF_MODE)) && !lock_q;
    time_wr_acc = wr_en && (addr == ADDR_W'(OFF_TIME)) && !lock_q;

    mode_d = mode_wr_acc ? (wdata & MODE_MASK) : mode_q;
    time_d = time_wr_acc ? (wdata & TIME_MASK) : time_q;
    lock_d = lock_q | lock_set;

    flag_d    = flag_q;
    flag_d[0] = flag_q[0] | uf_evt;
    flag_d[1] = flag_q[1] | er_evt;
    flag_d[2] = flag_q[2] | (mode_wr_acc && guard_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      time_q <= TIME_MASK;
      lock_q <= 1'b0;
      flag_q <= '0;
    end else begin
      mode_q <= mode_d;
      time_q <= time_d;
      lock_q <= lock_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFF_MODE): rdata = mode_q;
      ADDR_W'(OFF_TIME): rdata = time_q;
      ADDR_W'(OFF_STAT): begin
        rdata[2:0]               = flag_q;
        rdata[3]                 = lock_q;
        rdata[THR_LSB +: CNT_W]  = cnt;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdw_counter.sv
module wdw_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             halt,
  input  logic             disabled,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] thresh,
  input  logic             ufl_en,
  input  logic             early_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             uf_evt,
  output logic             er_evt
);
  logic [CNT_W-1:0] cnt_d;
  logic             step;

  always_comb begin
    step   = tick && !halt && (cnt_q != '0);
    er_evt = restart && early_en && !disabled && (cnt_q > thresh);
    uf_evt = !restart && step && (cnt_q == CNT_W'(1)) && ufl_en;
    if (restart)   cnt_d = period;
    else if (step) cnt_d = cnt_q - CNT_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdw_guard.sv
module wdw_guard #(
  parameter int GUARD_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic active
);
  localparam int GW = $clog2(GUARD_TICKS + 1);

  logic [GW-1:0] left_q, left_d;

  always_comb begin
    if (restart)                     left_d = GW'(GUARD_TICKS);
    else if (tick && left_q != '0)   left_d = left_q - GW'(1);
    else                             left_d = left_q;
    active = (left_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdw_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int CNT_W       = 12,
  parameter int GUARD_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              cpu_debug,
  input  logic              sys_idle,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst
);
  logic [DATA_W-1:0] mode_q, time_q;
  logic              lock_q, restart, mode_wr_acc, guard_act;
  logic [CNT_W-1:0]  cnt_q;
  logic              uf_evt, er_evt, halt, dis;
  logic              rst_q, rst_d;

  wdw_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cnt(cnt_q), .uf_evt(uf_evt), .er_evt(er_evt), .guard_act(guard_act),
    .mode_q(mode_q), .time_q(time_q), .lock_q(lock_q), .restart(restart),
    .mode_wr_acc(mode_wr_acc), .rdata(bus_rdata)
  );

  always_comb begin
    dis  = mode_q[MB_DISABLE];
    halt = dis || (mode_q[MB_DBG_HOLD] && cpu_debug) || (mode_q[MB_IDLE_HOLD] && sys_idle);
    rst_d = uf_evt || er_evt;
  end

  wdw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .halt(halt), .disabled(dis),
    .restart(restart), .period(time_q[CNT_W-1:0]), .thresh(time_q[THR_LSB +: CNT_W]),
    .ufl_en(mode_q[MB_UFL_RST]), .early_en(mode_q[MB_EARLY_RST]),
    .cnt_q(cnt_q), .uf_evt(uf_evt), .er_evt(er_evt)
  );

  wdw_guard #(.GUARD_TICKS(GUARD_TICKS)) u_guard (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .restart(restart), .active(guard_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= rst_d;
  end

  assign wdt_rst = rst_q;
endmodule

// File: rtl/wdw_checker.sv
module wdw_checker
  import wdw_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wdt_rst,
  input logic              lock_q,
  input logic              mode_wr,
  input logic [DATA_W-1:0] mode_q,
  input logic              restart,
  input logic              slow_tick,
  input logic              halt,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  period
);
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  assert_underflow_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_tick && !halt && !restart && cnt_q == CNT_W'(1) && mode_q[MB_UFL_RST]) |=> wdt_rst);

  assert_restart_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == $past(period)));

  assert_disable_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[MB_DISABLE] && !restart) |=> $stable(cnt_q));

  assert_disable_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[MB_DISABLE] |=> !wdt_rst);

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  assert_lock_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && mode_wr) |=> $stable(mode_q));
endmodule

bind wdog_window wdw_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .lock_q(lock_q),
  .mode_wr(bus_wr && (bus_addr == ADDR_W'(wdw_pkg::OFF_MODE))),
  .mode_q(mode_q), .restart(restart), .slow_tick(slow_tick), .halt(halt),
  .cnt_q(cnt_q), .period(time_q[CNT_W-1:0])
);

// File: tb/wdog_window_test.sv
module wdog_window_test;
  localparam int CLK_NS = 10;
  localparam int ADDR_W = 4;
  localparam int LIMIT  = 100000;

  logic        clk, rst_n, slow_tick, cpu_debug, sys_idle, bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        wdt_rst;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  wdog_window #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .cpu_debug(cpu_debug),
    .sys_idle(sys_idle), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) if (rst_n && wdt_rst) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; slow_tick = 0; cpu_debug = 0; sys_idle = 0;
    bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pulses = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] cnt_of(input logic [31:0] s);
    return {20'd0, s[27:16]};
  endfunction

  task automatic restart(); wr(4'h0, 32'hA500_0001); endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    rd(4'h4, v); chk("R1 mode", v, 32'h30);
    rd(4'h8, v); chk("R1 timing", v, 32'h0FFF0FFF);
    rd(4'hC, v); chk("R1 flags", {28'd0, v[3:0]}, 0);
    chk("R1 count", cnt_of(v), 32'hFFF);
    chk("R1 rst low", {31'd0, wdt_rst}, 0);
  endtask

  task automatic t_underflow();
    logic [31:0] v;
    do_reset();
    wr(4'h8, 32'h0FFF_000A);
    restart();
    rd(4'hC, v); chk("R2 reload", cnt_of(v), 10);
    ticks(3);
    rd(4'hC, v); chk("R3 decrement", cnt_of(v), 7);
    wr(4'h0, 32'h5A00_0001);
    rd(4'hC, v); chk("R2 bad key ignored", cnt_of(v), 7);
    ticks(6);
    chk("R4 no pulse before zero", pulses, 0);
    ticks(1);
    rd(4'hC, v);
    chk("R4 count zero", cnt_of(v), 0);
    chk("R4 one pulse", pulses, 1);
    chk("R4 cause bit", {31'd0, v[0]}, 1);
    ticks(3);
    chk("R4 parked no repeat", pulses, 1);
  endtask

  task automatic t_no_ufl_reset();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'h20);
    wr(4'h8, 32'h0FFF_000A);
    restart();
    ticks(10);
    rd(4'hC, v);
    chk("R4 off count zero", cnt_of(v), 0);
    chk("R4 off no pulse", pulses, 0);
    chk("R4 off no cause", {31'd0, v[0]}, 0);
  endtask

  task automatic t_early();
    logic [31:0] v;
    do_reset();
    wr(4'h8, 32'h0004_000A);
    restart();
    rd(4'hC, v);
    chk("R5 early from reset count", pulses, 1);
    chk("R5 cause bit", {31'd0, v[1]}, 1);
    chk("R5 reload", cnt_of(v), 10);
    ticks(2);
    restart();
    chk("R5 early above thr", pulses, 2);
    ticks(6);
    restart();
    chk("R5 at thr silent", pulses, 2);
    ticks(3);
    wr(4'h4, 32'h10);
    restart();
    rd(4'hC, v);
    chk("R5 window off silent", pulses, 2);
    chk("R5 window off reload", cnt_of(v), 10);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    do_reset();
    wr(4'h8, 32'h0004_000A);
    wr(4'h4, 32'h1030);
    restart();
    ticks(12);
    rd(4'hC, v);
    chk("R6 held", cnt_of(v), 10);
    chk("R6 no pulse", pulses, 0);
  endtask

  task automatic t_halts();
    logic [31:0] v;
    do_reset();
    wr(4'h8, 32'h0FFF_000A);
    wr(4'h4, 32'h3000_0030);
    restart();
    cpu_debug = 1; ticks(3);
    rd(4'hC, v); chk("R7 debug hold", cnt_of(v), 10);
    cpu_debug = 0; sys_idle = 1; ticks(2);
    rd(4'hC, v); chk("R7 idle hold", cnt_of(v), 10);
    sys_idle = 0; ticks(2);
    rd(4'hC, v); chk("R7 runs", cnt_of(v), 8);
    wr(4'h4, 32'h30);
    cpu_debug = 1; sys_idle = 1; ticks(2);
    rd(4'hC, v); chk("R7 bits clear no hold", cnt_of(v), 6);
    cpu_debug = 0; sys_idle = 0;
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    wr(4'h0, 32'h0000_0002);
    rd(4'hC, v); chk("R8 bad key no lock", {31'd0, v[3]}, 0);
    wr(4'h4, 32'h20);
    rd(4'h4, v); chk("R8 unlocked write", v, 32'h20);
    wr(4'h0, 32'hA500_0002);
    rd(4'hC, v); chk("R8 locked flag", {31'd0, v[3]}, 1);
    wr(4'h4, 32'h1030);
    rd(4'h4, v); chk("R8 mode frozen", v, 32'h20);
    wr(4'h8, 32'h0001_0001);
    rd(4'h8, v); chk("R8 timing frozen", v, 32'h0FFF0FFF);
    do_reset();
    rd(4'hC, v); chk("R8 reset clears", {31'd0, v[3]}, 0);
    wr(4'h4, 32'h10);
    rd(4'h4, v); chk("R8 writable after reset", v, 32'h10);
  endtask

  task automatic t_guard(input int gap, input logic exp);
    logic [31:0] v;
    do_reset();
    wr(4'h8, 32'h0FFF_000A);
    restart();
    if (gap > 0) ticks(gap);
    wr(4'h4, 32'h30);
    rd(4'hC, v);
    chk($sformatf("R9 guard gap %0d", gap), {31'd0, v[2]}, {31'd0, exp});
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_underflow();
    t_no_ufl_reset();
    t_early();
    t_disable();
    t_halts();
    t_lock();
    t_guard(0, 1'b1);
    t_guard(2, 1'b1);
    t_guard(3, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule